// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects up to 32 level-sensitive interrupt lines from peripherals and presents them to a processor core through a small register bus. Each line is sampled into a raw pending register once per clock. It is then gated by a per-source enable mask and sent either to the normal interrupt output or to the fast interrupt output, as a per-source routing register selects. Software reads the masked pending word of either class. It can also read one combined winner register, which names the highest-priority pending source of each class together with a valid flag.

Priority comes from a programmable slot table rather than a fixed encoder. Each slot names a source and carries a valid bit. Slot 0 ranks highest, and the resolver picks the lowest-numbered valid slot whose named source is eligible. A wake output tells the power controller that something needs the core. A control bit chooses whether any raw pending line can raise it, or only lines that are also enabled.

The register bus is plain control and has no back-pressure. A write with `bus_sel` and `bus_wr` high takes effect at that clock edge. Read data is a combinational function of `bus_addr` and the current state, and is never stalled. Pending bits follow the source lines; a bus write never clears them.

Top module: `prio_intc`

## Requirements
- R1: After reset the enable mask (0x04), the routing register (0x08) and the control register (0x14) read 0. Slot k (offset 0x1C + 4k) reads with bit 31 set and source ID k in its low bits.
- R2: The mask, the routing register, control bit 0, and each slot's valid bit 31 and ID bits [4:0] are written by a bus write to their offset and read back unchanged. Unused slot bits read 0.
- R3: The raw pending word (0x10) equals the source lines as sampled at the previous clock edge.
- R4: The normal pending word (0x00) is raw AND mask AND NOT routing. A routing bit of 0 means normal class. `irq_out` is the OR of this word.
- R5: The fast pending word (0x0C) is raw AND mask AND routing. A routing bit of 1 means fast class. `fiq_out` is the OR of this word.
- R6: In the winner register (0x18), bit 31 is set when some valid slot names a source that is pending in the normal class. Bits 30:16 then hold the source ID from the lowest-numbered such slot.
- R7: In the winner register, bit 15 and bits 14:0 report the fast class by the same slot rule.
- R8: A slot whose valid bit is 0 never wins. When no slot qualifies for a class, that class's valid flag and ID field read 0.
- R9: With control bit 0 equal to 1, `wake_out` is the OR of raw AND mask. With it equal to 0, `wake_out` is the OR of raw alone.
- R10: Writes to offsets 0x00, 0x0C, 0x10 and 0x18 change no register and clear no pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | 32 | Level interrupt lines, one per source |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |
| wake_out | output | 1 | Idle wake request |

## Verification
The assertions assume the source lines are synchronous to `clk` and held steady around each edge. They also assume that bus writes target word-aligned offsets, so a slot write never straddles two slots. The bench changes sources and bus signals only on falling edges and uses only aligned offsets. It does reprogram slots freely, including invalid slots and two slots naming the same source, because the winner assertions only tie a valid flag to its class output and an invalid flag to a zero ID.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned HP_ID_W = 15;

  localparam logic [7:0] OFF_IRQ_PEND = 8'h00;
  localparam logic [7:0] OFF_MASK     = 8'h04;
  localparam logic [7:0] OFF_ROUTE    = 8'h08;
  localparam logic [7:0] OFF_FIQ_PEND = 8'h0C;
  localparam logic [7:0] OFF_RAW      = 8'h10;
  localparam logic [7:0] OFF_CTRL     = 8'h14;
  localparam logic [7:0] OFF_WINNER   = 8'h18;
  localparam logic [7:0] OFF_SLOT0    = 8'h1C;
  localparam int unsigned SLOT_STRIDE = 4;
endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned ID_W   = 5,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_sel,
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [DATA_W-1:0]               bus_wdata,
  output logic [NSRC-1:0]                 mask_q,
  output logic [NSRC-1:0]                 route_q,
  output logic                            wake_sel_q,
  output logic [NSRC-1:0]                 slot_vld,
  output logic [NSRC-1:0][ID_W-1:0]       slot_id
);
  logic wr_en;
  assign wr_en = bus_sel && bus_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q     <= '0;
      route_q    <= '0;
      wake_sel_q <= 1'b0;
    end else if (wr_en) begin
      if (bus_addr == ADDR_W'(OFF_MASK))  mask_q     <= bus_wdata[NSRC-1:0];
      if (bus_addr == ADDR_W'(OFF_ROUTE)) route_q    <= bus_wdata[NSRC-1:0];
      if (bus_addr == ADDR_W'(OFF_CTRL))  wake_sel_q <= bus_wdata[0];
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(OFF_SLOT0 + SLOT_STRIDE * g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_vld[g] <= 1'b1;
        slot_id[g]  <= ID_W'(g);
      end else if (wr_en && bus_addr == SLOT_ADDR) begin
        slot_vld[g] <= bus_wdata[DATA_W-1];
        slot_id[g]  <= bus_wdata[ID_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver #(
  parameter int unsigned NSRC = 32,
  parameter int unsigned ID_W = 5
) (
  input  logic [NSRC-1:0]           elig,
  input  logic [NSRC-1:0]           slot_vld,
  input  logic [NSRC-1:0][ID_W-1:0] slot_id,
  output logic                      found,
  output logic [ID_W-1:0]           win_id
);
  // Walk from the lowest-ranked slot upward so the highest-ranked hit is the last assignment.
  always_comb begin
    found  = 1'b0;
    win_id = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (slot_vld[i] && (int'(slot_id[i]) < NSRC) && elig[slot_id[i]]) begin
        found  = 1'b1;
        win_id = slot_id[i];
      end
    end
  end
endmodule

// File: rtl/pic_readback.sv
module pic_readback
  import pic_pkg::*;
#(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned ID_W   = 5,
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic [NSRC-1:0]           irq_pend,
  input  logic [NSRC-1:0]           fiq_pend,
  input  logic [NSRC-1:0]           raw_q,
  input  logic [NSRC-1:0]           mask_q,
  input  logic [NSRC-1:0]           route_q,
  input  logic                      wake_sel_q,
  input  logic [DATA_W-1:0]         winner,
  input  logic [NSRC-1:0]           slot_vld,
  input  logic [NSRC-1:0][ID_W-1:0] slot_id,
  output logic [DATA_W-1:0]         rdata
);
  localparam int unsigned PAD_W = DATA_W - 1 - ID_W;

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_W'(OFF_IRQ_PEND): rdata = DATA_W'(irq_pend);
      ADDR_W'(OFF_MASK):     rdata = DATA_W'(mask_q);
      ADDR_W'(OFF_ROUTE):    rdata = DATA_W'(route_q);
      ADDR_W'(OFF_FIQ_PEND): rdata = DATA_W'(fiq_pend);
      ADDR_W'(OFF_RAW):      rdata = DATA_W'(raw_q);
      ADDR_W'(OFF_CTRL):     rdata = DATA_W'(wake_sel_q);
      ADDR_W'(OFF_WINNER):   rdata = winner;
      default: begin
        for (int i = 0; i < NSRC; i++) begin
          if (addr == ADDR_W'(OFF_SLOT0 + SLOT_STRIDE * i))
            rdata = {slot_vld[i], {PAD_W{1'b0}}, slot_id[i]};
        end
      end
    endcase
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import pic_pkg::*;
#(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_lvl,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out,
  output logic              fiq_out,
  output logic              wake_out
);
  localparam int unsigned ID_W  = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int unsigned EXT_W = HP_ID_W - ID_W;

  logic [NSRC-1:0]           raw_q;
  logic [NSRC-1:0]           mask_q;
  logic [NSRC-1:0]           route_q;
  logic                      wake_sel_q;
  logic [NSRC-1:0]           slot_vld;
  logic [NSRC-1:0][ID_W-1:0] slot_id;
  logic [NSRC-1:0]           irq_pend;
  logic [NSRC-1:0]           fiq_pend;
  logic                      irq_found;
  logic                      fiq_found;
  logic [ID_W-1:0]           irq_id;
  logic [ID_W-1:0]           fiq_id;
  logic [DATA_W-1:0]         hp_word;

  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= src_lvl;
  end

  pic_regs #(.NSRC(NSRC), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .mask_q(mask_q), .route_q(route_q), .wake_sel_q(wake_sel_q),
    .slot_vld(slot_vld), .slot_id(slot_id)
  );

  assign irq_pend = raw_q & mask_q & ~route_q;
  assign fiq_pend = raw_q & mask_q & route_q;

  pic_resolver #(.NSRC(NSRC), .ID_W(ID_W)) u_res_irq (
    .elig(irq_pend), .slot_vld(slot_vld), .slot_id(slot_id),
    .found(irq_found), .win_id(irq_id)
  );

  pic_resolver #(.NSRC(NSRC), .ID_W(ID_W)) u_res_fiq (
    .elig(fiq_pend), .slot_vld(slot_vld), .slot_id(slot_id),
    .found(fiq_found), .win_id(fiq_id)
  );

  assign hp_word = {irq_found, {EXT_W{1'b0}}, irq_id, fiq_found, {EXT_W{1'b0}}, fiq_id};

  pic_readback #(.NSRC(NSRC), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_rd (
    .addr(bus_addr), .irq_pend(irq_pend), .fiq_pend(fiq_pend), .raw_q(raw_q),
    .mask_q(mask_q), .route_q(route_q), .wake_sel_q(wake_sel_q), .winner(hp_word),
    .slot_vld(slot_vld), .slot_id(slot_id), .rdata(bus_rdata)
  );

  assign irq_out  = |irq_pend;
  assign fiq_out  = |fiq_pend;
  assign wake_out = wake_sel_q ? |(raw_q & mask_q) : |raw_q;
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int unsigned NSRC = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_lvl,
  input logic [NSRC-1:0] raw_q,
  input logic [NSRC-1:0] irq_pend,
  input logic [NSRC-1:0] fiq_pend,
  input logic [31:0]     hp_word,
  input logic            irq_out,
  input logic            fiq_out,
  input logic            wake_out
);
  AST_RAW_TRACKS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> raw_q == $past(src_lvl)); // R3
  AST_CLASSES_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend & fiq_pend) == '0); // R5
  AST_IRQ_WIN_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    hp_word[31] |-> irq_out); // R6
  AST_FIQ_WIN_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    hp_word[15] |-> fiq_out); // R7
  AST_NO_WIN_ZERO_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (!hp_word[31] |-> hp_word[30:16] == '0) and (!hp_word[15] |-> hp_word[14:0] == '0)); // R8
  AST_REQ_IMPLIES_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out || fiq_out) |-> wake_out); // R9
endmodule

bind prio_intc pic_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .raw_q(raw_q),
  .irq_pend(irq_pend), .fiq_pend(fiq_pend), .hp_word(hp_word),
  .irq_out(irq_out), .fiq_out(fiq_out), .wake_out(wake_out)
);

// File: tb/sim_prio_intc.sv
`timescale 1ns/1ps
module sim_prio_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_lvl = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out, fiq_out, wake_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prio_intc u0 (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .fiq_out(fiq_out), .wake_out(wake_out)
  );

  // Behavioural reference state
  logic [31:0] m_raw, m_mask, m_route;
  bit          m_ctrl;
  bit          m_sv [32];
  int          m_sid [32];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_raw <= 0; m_mask <= 0; m_route <= 0; m_ctrl <= 0;
      for (int k = 0; k < 32; k++) begin m_sv[k] <= 1; m_sid[k] <= k; end
    end else begin
      m_raw <= src_lvl;
      if (bus_sel && bus_wr) begin
        if (bus_addr == 8'h04) m_mask <= bus_wdata;
        if (bus_addr == 8'h08) m_route <= bus_wdata;
        if (bus_addr == 8'h14) m_ctrl <= bus_wdata[0];
        if (bus_addr >= 8'h1C && bus_addr < 8'h9C && bus_addr[1:0] == 2'b00) begin
          m_sv[(bus_addr - 8'h1C) / 4]  <= bus_wdata[31];
          m_sid[(bus_addr - 8'h1C) / 4] <= int'(bus_wdata[4:0]);
        end
      end
    end
  end

  function automatic logic [31:0] m_irq();
    return m_raw & m_mask & ~m_route;
  endfunction
  function automatic logic [31:0] m_fiq();
    return m_raw & m_mask & m_route;
  endfunction
  function automatic logic [15:0] m_pick(logic [31:0] elig);
    for (int k = 0; k < 32; k++)
      if (m_sv[k] && elig[m_sid[k]]) return 16'h8000 | 16'(m_sid[k]);
    return 16'h0000;
  endfunction
  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00: return m_irq();
      8'h04: return m_mask;
      8'h08: return m_route;
      8'h0C: return m_fiq();
      8'h10: return m_raw;
      8'h14: return {31'b0, m_ctrl};
      8'h18: return {m_pick(m_irq()), m_pick(m_fiq())};
      default: begin
        if (a >= 8'h1C && a < 8'h9C && a[1:0] == 2'b00)
          return {m_sv[(a - 8'h1C) / 4], 26'b0, 5'(m_sid[(a - 8'h1C) / 4])};
        return 32'h0;
      end
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Per-cycle comparison of the outputs, which depend only on registered state
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 irq_out", 32'(irq_out), 32'(|m_irq()));
      chk("R5 fiq_out", 32'(fiq_out), 32'(|m_fiq()));
      chk("R9 wake_out", 32'(wake_out), 32'(m_ctrl ? |(m_raw & m_mask) : |m_raw));
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(string req, logic [7:0] a);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1;
    chk(req, bus_rdata, m_read(a));
    bus_sel = 0;
  endtask

  task automatic rd_exp(string req, logic [7:0] a, logic [31:0] e);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1;
    chk(req, bus_rdata, e);
    bus_sel = 0;
  endtask

  task automatic set_src(logic [31:0] v);
    @(negedge clk);
    src_lvl = v;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1: reset values, with literal expectations
    rd_exp("R1 mask", 8'h04, 32'h0);
    rd_exp("R1 route", 8'h08, 32'h0);
    rd_exp("R1 ctrl", 8'h14, 32'h0);
    rd_exp("R1 slot0", 8'h1C, 32'h8000_0000);
    rd_exp("R1 slot31", 8'h98, 32'h8000_001F);
    rd_exp("R8 winner idle", 8'h18, 32'h0);

    // R3: raw follows lines; edge sources 0 and 31
    set_src(32'h8000_0001);
    rd_exp("R3 raw", 8'h10, 32'h8000_0001);
    rd_exp("R4 masked off", 8'h00, 32'h0);
    chk("R9 wake any raw", 32'(wake_out), 32'h1);

    wr(8'h14, 32'h1);
    rd_exp("R2 ctrl", 8'h14, 32'h1);
    chk("R9 wake masked", 32'(wake_out), 32'h0);

    wr(8'h04, 32'hFFFF_FFFF);
    rd_exp("R2 mask", 8'h04, 32'hFFFF_FFFF);
    rd_exp("R4 irq pend", 8'h00, 32'h8000_0001);
    rd_exp("R6 winner src0", 8'h18, 32'h8000_0000);

    wr(8'h08, 32'h0000_0001);
    rd_exp("R5 fiq pend", 8'h0C, 32'h0000_0001);
    rd_exp("R7 winner split", 8'h18, 32'h801F_8000);

    wr(8'h1C, 32'h0000_0000);
    rd_exp("R2 slot0", 8'h1C, 32'h0);
    rd_exp("R8 invalid slot", 8'h18, 32'h801F_0000);
    wr(8'h28, 32'hFFFF_FFFF);
    rd_exp("R2 slot3 pad", 8'h28, 32'h8000_001F);

    // Mixed pattern
    set_src(32'h0000_F0F0);
    wr(8'h04, 32'h0000_FF00);
    wr(8'h08, 32'h0000_3000);
    rd("R4 mixed", 8'h00);
    rd("R5 mixed", 8'h0C);
    rd("R6 mixed", 8'h18);
    wr(8'h4C, 32'h8000_000D);
    rd("R7 dup slot", 8'h18);

    // R10: writes to read-only offsets have no effect
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h0C, 32'h0);
    wr(8'h10, 32'h0);
    wr(8'h18, 32'h0);
    rd_exp("R10 raw kept", 8'h10, 32'h0000_F0F0);
    rd("R10 irq kept", 8'h00);
    rd("R10 fiq kept", 8'h0C);
    rd("R10 winner kept", 8'h18);
    rd_exp("R10 mask kept", 8'h04, 32'h0000_FF00);

    // Wake from a masked-off line only
    set_src(32'h0000_0001);
    chk("R9 masked only", 32'(wake_out), 32'h0);
    wr(8'h14, 32'h0);
    chk("R9 any line", 32'(wake_out), 32'h1);

    set_src(32'h0);
    rd_exp("R8 nothing", 8'h18, 32'h0);
    rd("R3 cleared", 8'h10);

    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule